// File: doc/BRIEF.md
# Four-Mode SPI Master with Clock-Mask Translation

This block is an SPI master that swaps one byte per transfer with a single servant. Internally it runs only one timing: a native clock that idles high, drives a new MOSI bit on each falling edge and samples MISO on each rising edge. A registered mask stage and a selectable output inverter turn that native clock into the bus clock for any of the four SPI modes. Modes 0 and 2 are produced by holding the bus clock low through the native clock's leading fall. The mask lets go only once the native clock is high again, and it is reapplied after the last sample to give the servant its closing half cycle. Modes 1 and 2 are the inverted forms of modes 3 and 0.

A host presents a byte and a two-bit mode code, then pulses `start`. The block lowers the active-low select, runs eight bit cycles MSB first, raises select and pulses `done` with the received byte on `rx_data`. A built-in divider sets the bus half period to `HALF_DIV` system clocks, so `HALF_DIV = 1` gives a bus clock of half the system rate.

Top module: `spi_mode_master`

## Requirements
- R1: After reset, `sel_n` is 1, `sclk` is 1, `done` is 0 and `rx_data` is 0.
- R2: The servant receives `tx_data` most significant bit first in every mode. MOSI never changes on a sampling edge.
- R3: When `done` is high, `rx_data` holds the eight MISO bits captured on the sampling edges, the first bit captured in bit 7.
- R4: Mode code bit 1 is the clock idle level (CPOL) and bit 0 is the phase (CPHA: 0 means the servant samples on the leading edge, 1 means it shifts on the leading edge). While `sel_n` is high, `sclk` does not change except in the cycle select falls, and after a transfer it rests at CPOL.
- R5: In every mode, exactly 16 bus clock edges occur while select is low: 8 leading and 8 trailing. In modes 0 and 2 the last one comes from reapplying the mask.
- R6: The first bus edge comes 2·HALF_DIV cycles after select falls in modes 1 and 3, and 3·HALF_DIV cycles after in modes 0 and 2. The mask never releases while the native clock is low, so no partial pulse reaches the bus.
- R7: Consecutive bus edges within a transfer are exactly HALF_DIV system clocks apart.
- R8: Select stays low for exactly (2·8+4)·HALF_DIV system clocks per transfer.
- R9: `done` is high for exactly one cycle, in the same cycle that `sel_n` returns high.
- R10: A `start` pulse during a transfer is ignored. It changes neither that transfer's data nor its timing, and it launches no later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| mode | input | 2 | SPI mode code, {CPOL, CPHA} |
| tx_data | input | DATA_W | Byte to send |
| rx_data | output | DATA_W | Byte received, updated with `done` |
| done | output | 1 | One-cycle end-of-transfer strobe |
| sclk | output | 1 | Bus serial clock |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |
| sel_n | output | 1 | Active-low servant select |

## Verification
A mask that stays set one cycle too long, or drops while the native clock is low, shows within the first bit. The servant then sees a missing or extra edge, so the edge count differs from 16 and the first-edge delay is wrong, and the byte exchanged is shifted by one position. Both show by the end of the same transfer. A bit-index or divider fault changes the select-low length or the edge spacing, and this is measured at the ports during the transfer in which it occurs. A stale mode register shows as a wrong idle level at the first `done`.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_BITS, ST_TRAIL} seq_e;

  // clock idle level of a mode code
  function automatic logic idle_level(input logic [1:0] m);
    return m[1];
  endfunction

  // even modes need the native leading fall hidden by the mask
  function automatic logic needs_mask(input logic [1:0] m);
    return ~m[0];
  endfunction

  // modes 1 and 2 are inverted images of 3 and 0
  function automatic logic needs_invert(input logic [1:0] m);
    return m[1] ^ m[0];
  endfunction
endpackage

// File: rtl/spi_mm_divider.sv
module spi_mm_divider #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_mm_clkmask.sv
module spi_mm_clkmask (
  input  logic clk,
  input  logic rst_n,
  input  logic nclk_nx,
  input  logic mask_req_nx,
  input  logic inv_nx,
  output logic sclk,
  output logic nclk_q,
  output logic mask_q
);
  logic mask_d;
  logic bus_d;

  // the mask sets at once but clears only once the native clock is high
  assign mask_d = mask_req_nx | (mask_q & ~nclk_nx);
  assign bus_d  = (nclk_nx & ~mask_d) ^ inv_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nclk_q <= 1'b1;
      mask_q <= 1'b0;
      sclk   <= 1'b1;
    end else begin
      nclk_q <= nclk_nx;
      mask_q <= mask_d;
      sclk   <= bus_d;
    end
  end
endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_out,
  input  logic         sample,
  input  logic         capture,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else begin
      if (load)           tx_q <= load_val;
      else if (shift_out) begin
        mosi <= tx_q[W-1];
        tx_q <= {tx_q[W-2:0], 1'b0};
      end
      if (sample)  rx_q    <= {rx_q[W-2:0], miso};
      if (capture) rx_word <= rx_q;
    end
  end
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              sel_n
);
  localparam int EDGE_N = 2 * DATA_W;
  localparam int IDX_W  = $clog2(EDGE_N + 1);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(EDGE_N - 1);
  localparam logic [IDX_W-1:0] LEAD_END  = IDX_W'(1);
  localparam logic [IDX_W-1:0] TRAIL_END = IDX_W'(2);

  seq_e             st_q, st_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic [1:0]       mode_q, mode_nx;
  logic             sel_q, sel_nx;
  logic             done_q, done_nx;
  logic             nclk_nx, mask_req_nx;
  logic             load_w, shift_w, sample_w, capture_w;

  // internal events brought out for the checker
  logic tick_w;
  logic nclk_w;
  logic mask_w;
  logic busy_w;

  assign busy_w = (st_q != ST_IDLE);

  spi_mm_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .tick(tick_w)
  );

  always_comb begin
    st_nx     = st_q;
    idx_nx    = idx_q;
    mode_nx   = mode_q;
    sel_nx    = sel_q;
    done_nx   = 1'b0;
    nclk_nx   = nclk_w;
    load_w    = 1'b0;
    shift_w   = 1'b0;
    sample_w  = 1'b0;
    capture_w = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_nx   = ST_LEAD;
        idx_nx  = '0;
        sel_nx  = 1'b0;
        mode_nx = mode;
        load_w  = 1'b1;
      end
      ST_LEAD: if (tick_w) begin
        if (idx_q == LEAD_END) begin
          st_nx   = ST_BITS;
          idx_nx  = IDX_W'(1);
          nclk_nx = 1'b0;
          shift_w = 1'b1;
        end else begin
          idx_nx = idx_q + 1'b1;
        end
      end
      ST_BITS: if (tick_w) begin
        if (idx_q[0]) begin
          nclk_nx  = 1'b1;
          sample_w = 1'b1;
          if (idx_q == LAST_EDGE) begin
            st_nx  = ST_TRAIL;
            idx_nx = '0;
          end else begin
            idx_nx = idx_q + 1'b1;
          end
        end else begin
          nclk_nx = 1'b0;
          shift_w = 1'b1;
          idx_nx  = idx_q + 1'b1;
        end
      end
      ST_TRAIL: if (tick_w) begin
        if (idx_q == TRAIL_END) begin
          st_nx     = ST_IDLE;
          sel_nx    = 1'b1;
          done_nx   = 1'b1;
          capture_w = 1'b1;
        end else begin
          idx_nx = idx_q + 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
    // mask held everywhere except during the bits and the first trail slot
    mask_req_nx = needs_mask(mode_nx) &&
                  !((st_nx == ST_BITS) || ((st_nx == ST_TRAIL) && (idx_nx == '0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      mode_q <= 2'd3;
      sel_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      idx_q  <= idx_nx;
      mode_q <= mode_nx;
      sel_q  <= sel_nx;
      done_q <= done_nx;
    end
  end

  spi_mm_clkmask u_mask (
    .clk(clk), .rst_n(rst_n),
    .nclk_nx(nclk_nx), .mask_req_nx(mask_req_nx), .inv_nx(needs_invert(mode_nx)),
    .sclk(sclk), .nclk_q(nclk_w), .mask_q(mask_w)
  );

  spi_mm_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load_w), .load_val(tx_data), .shift_out(shift_w),
    .sample(sample_w), .capture(capture_w), .miso(miso),
    .mosi(mosi), .rx_word(rx_data)
  );

  assign sel_n = sel_q;
  assign done  = done_q;
endmodule

// File: rtl/spi_mode_master_chk.sv
module spi_mode_master_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic sel_n,
  input logic sclk,
  input logic mosi,
  input logic tick,
  input logic nclk,
  input logic mask
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(sel_n));

  // R6
  mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask) |-> nclk);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n) && sel_n) |-> $stable(sclk));

  // R7
  sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(sel_n) && !sel_n) |-> $stable(sclk));

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nclk) |-> $stable(mosi));
endmodule

bind spi_mode_master spi_mode_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .sel_n(sel_n), .sclk(sclk),
  .mosi(mosi), .tick(tick_w), .nclk(nclk_w), .mask(mask_w)
);

// File: tb/sim_spi_mode_master.sv
module sim_spi_mode_master;
  localparam int W = 8;
  localparam int D = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] rx_data;
  logic         done, sclk, mosi, sel_n;
  logic         miso = 1'b0;

  int applied = 0;
  int bad = 0;

  spi_mode_master #(.DATA_W(W), .HALF_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .tx_data(tx_data),
    .rx_data(rx_data), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso),
    .sel_n(sel_n)
  );

  always #4 clk = ~clk;

  // servant model and bus observer
  logic         s_cpol = 1'b1, s_cpha = 1'b1;
  logic [W-1:0] srv_byte = '0, s_tx = '0, s_rx = '0;
  logic         prev_sel = 1'b1, prev_sclk = 1'b1, done_at_rise = 1'b0;
  int cyc = 0, edges = 0, samples = 0, first_edge = -1, last_edge = 0;
  int spacing_bad = 0, done_cnt = 0, low_len = 0;

  always @(negedge clk) begin
    if (prev_sel && !sel_n) begin
      cyc = 0; edges = 0; samples = 0; s_rx = '0; first_edge = -1;
      last_edge = 0; spacing_bad = 0; done_cnt = 0; s_tx = srv_byte;
      if (!s_cpha) begin miso = s_tx[W-1]; s_tx = s_tx << 1; end
    end else if (!prev_sel && !sel_n) begin
      cyc++;
      if (sclk != prev_sclk) begin
        edges++;
        if (first_edge < 0) first_edge = cyc;
        else if (cyc - last_edge != D) spacing_bad++;
        last_edge = cyc;
        if ((sclk != s_cpol) != s_cpha) begin
          s_rx = {s_rx[W-2:0], mosi};
          samples++;
        end else begin
          miso = s_tx[W-1];
          s_tx = s_tx << 1;
        end
      end
    end else if (!prev_sel && sel_n) begin
      low_len = cyc + 1;
      done_at_rise = done;
    end
    if (done) done_cnt++;
    prev_sel = sel_n;
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_edge_exp(input logic [1:0] m);
    return m[0] ? 2 * D : 3 * D;
  endfunction

  task automatic xfer(input logic [1:0] m, input logic [W-1:0] tx,
                      input logic [W-1:0] srv, input bit inject);
    int waited = 0;
    @(negedge clk);
    mode = m; tx_data = tx; srv_byte = srv;
    s_cpol = m[1]; s_cpha = m[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (5 * D) @(negedge clk);
      mode = ~m; tx_data = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!(done_cnt > 0 && sel_n) && waited < 2000) begin
      @(negedge clk); waited++;
    end
    check(waited < 2000, "R9 timeout", waited, 0);
    check(s_rx == tx, "R2 servant byte", s_rx, tx);
    check(rx_data == srv, "R3 rx_data", rx_data, srv);
    check(sclk == m[1], "R4 idle level", sclk, m[1]);
    check(edges == 16 && samples == 8, "R5 edge count", edges, 16);
    check(first_edge == first_edge_exp(m), "R6 first edge", first_edge, first_edge_exp(m));
    check(spacing_bad == 0, "R7 edge spacing", spacing_bad, 0);
    check(low_len == (2 * W + 4) * D, "R8 select length", low_len, (2 * W + 4) * D);
    check(done_cnt == 1 && done_at_rise, "R9 done pulse", done_cnt, 1);
    if (inject) begin
      repeat (3 * D + 2) @(negedge clk);
      check(sel_n == 1'b1 && done_cnt == 1, "R10 start ignored", done_cnt, 1);
    end
  endtask

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sel_n == 1'b1, "R1 sel_n", sel_n, 1);
    check(sclk == 1'b1, "R1 sclk", sclk, 1);
    check(done == 1'b0, "R1 done", done, 0);
    check(rx_data == '0, "R1 rx_data", rx_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed: every mode, edge bytes
    xfer(2'd3, 8'hA5, 8'h3C, 1'b0);
    xfer(2'd0, 8'h80, 8'h01, 1'b0);
    xfer(2'd1, 8'hFF, 8'h00, 1'b0);
    xfer(2'd2, 8'h01, 8'hFE, 1'b0);
    xfer(2'd0, 8'h00, 8'hFF, 1'b1);
    xfer(2'd3, 8'h5A, 8'h96, 1'b1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      xfer(2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom), ($urandom_range(0, 4) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule